// File: doc/BRIEF.md
# SVM Operand Layout Sequencer for a Convolution Engine

This block lets a convolution engine evaluate a linear-kernel SVM decision function without modification. The SVM layer is a product of a weight matrix of `msvm` rows by `nsvm` columns with a batch of input vectors. The sequencer turns that product into convolution geometry. It then walks every operand word once, giving the buffer, channel and address each word goes to, and which source word (input vector or weight row, and element index) supplies it.

Every vector of length `nsvm` is folded across the engine's `TN` input channels. Each channel then holds a window of K = ceil(nsvm/TN) words. Because the kernel length and the stride are both K, the windows never overlap. One mode bit selects the orientation:
- With mode 0, the input vectors form the feature map and the weight rows form the kernels.
- With mode 1, the weight matrix forms the feature map and the input vectors form the kernels. The batch then lies on the output-channel axis, so the batch should sit at or near the engine's output parallelism.

The sequencer raises `ready` once every feature-map and kernel word has been issued. Fetching data from external memory and choosing the mode are left to surrounding logic.

Top module: `svm_operand_mapper`

## Requirements
- R1: While reset is active and after it is released, `ready` and `wr_valid` are 0 until a start is accepted.
- R2: A `start` is accepted only when no layout is running and `batch`, `msvm` and `nsvm` are all nonzero. A start with a zero dimension, or a start during a run, has no effect: no write is issued and the geometry outputs stay unchanged.
- R3: After acceptance, `geo_fm_cols`, `geo_ker_len` and `geo_stride` all equal K = ceil(nsvm/TN).
- R4: In mode 0, `geo_fm_rows` and `geo_out_size` equal `batch`, and `geo_out_ch` equals `msvm`.
- R5: In mode 1, `geo_fm_rows` and `geo_out_size` equal `msvm`, and `geo_out_ch` equals `batch`.
- R6: The first write comes in the cycle after acceptance, and there is one write per cycle with no gaps. All feature-map writes (`wr_buf`=0) come first, followed by all kernel writes (`wr_buf`=1). Within each phase, rows are issued in ascending order and elements n = 0..K·TN−1 in ascending order within each row.
- R7: Element n of row r goes to channel n mod TN (`wr_chan`) at address r·K + n div TN (`wr_addr`).
- R8: A write whose element index n is at least `nsvm` is a pad and has `wr_zero`=1; all other writes have `wr_zero`=0.
- R9: `src_kind` is 0 for an input vector and 1 for a weight row. It equals `mode` during feature-map writes and the inverse of `mode` during kernel writes. `src_row` is the row index r and `src_elem` is n.
- R10: `ready` rises in the cycle after the last kernel write. It then holds, with no writes, until the next accepted start.
- R11: `geo_fits` is 1 exactly when geo_fm_rows·K ≤ FM_WORDS and geo_out_ch·K ≤ KER_WORDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to lay out one SVM layer |
| mode | input | 1 | 0: vectors form feature map; 1: weights form feature map |
| batch | input | BW | Number of input vectors |
| msvm | input | MW | Rows of the weight matrix |
| nsvm | input | NW | Vector length |
| ready | output | 1 | All operand words issued |
| wr_valid | output | 1 | A write is issued this cycle |
| wr_buf | output | 1 | 0 feature-map buffer, 1 kernel buffer |
| wr_chan | output | TN_LG2 | Input channel of the write |
| wr_addr | output | AW | Word address within the channel |
| src_kind | output | 1 | 0 input vector, 1 weight row |
| src_row | output | RW | Source vector or weight row index |
| src_elem | output | EW | Source element index |
| wr_zero | output | 1 | Write a zero pad instead of source data |
| geo_fm_rows | output | RW | Feature-map rows |
| geo_fm_cols | output | KW | Feature-map columns (K) |
| geo_out_ch | output | RW | Output channels (kernel count) |
| geo_out_size | output | RW | Output map size |
| geo_ker_len | output | KW | Kernel length |
| geo_stride | output | KW | Kernel stride |
| geo_fits | output | 1 | Operands fit both buffers |

## Verification
The hardest situation to reach is a start request that arrives in the middle of a layout, carrying a different mode and different dimensions. It must leave both the running write stream and the captured geometry untouched. The stimulus handles this in every run of the sweep: at a write index that varies with the configuration, it raises `start` with the opposite mode and altered sizes. It then keeps checking every following write and re-checks the geometry at the end. Pad writes at the end of every row are covered by sweeping `nsvm` through every remainder modulo TN.

// File: rtl/svm_map_pkg.sv
package svm_map_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FM   = 2'd1,
        PH_KER  = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

endpackage

// File: rtl/svm_map_geom.sv
module svm_map_geom #(
    parameter int TN_LG2    = 2,
    parameter int NW        = 7,
    parameter int BW        = 5,
    parameter int MW        = 5,
    parameter int RW        = 5,
    parameter int KW        = 5,
    parameter int FM_WORDS  = 512,
    parameter int KER_WORDS = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          busy,
    input  logic          mode,
    input  logic [BW-1:0] batch,
    input  logic [MW-1:0] msvm,
    input  logic [NW-1:0] nsvm,
    output logic          mode_q,
    output logic [NW-1:0] nsvm_q,
    output logic [RW-1:0] rows_q,
    output logic [RW-1:0] kerns_q,
    output logic [KW-1:0] k_q,
    output logic          fits_q
);
    localparam int TN = 1 << TN_LG2;

    typedef struct packed {
        logic          mode;
        logic [NW-1:0] nsvm;
        logic [RW-1:0] rows;
        logic [RW-1:0] kerns;
        logic [KW-1:0] k;
        logic          fits;
    } geo_t;

    geo_t g_d, g_q;

    logic [NW:0]   n_round;
    logic [KW-1:0] k_new;
    logic [RW-1:0] b_ext, m_ext, rows_new, kerns_new;
    logic [31:0]   fm_need, ker_need;

    always_comb begin
        n_round   = {1'b0, nsvm} + (NW+1)'(TN - 1);
        k_new     = KW'(n_round >> TN_LG2);
        b_ext     = RW'(batch);
        m_ext     = RW'(msvm);
        rows_new  = mode ? m_ext : b_ext;
        kerns_new = mode ? b_ext : m_ext;
        fm_need   = 32'(rows_new) * 32'(k_new);
        ker_need  = 32'(kerns_new) * 32'(k_new);

        g_d = g_q;
        if (accept) begin
            g_d.mode  = mode;
            g_d.nsvm  = nsvm;
            g_d.rows  = rows_new;
            g_d.kerns = kerns_new;
            g_d.k     = k_new;
            g_d.fits  = (fm_need <= 32'(FM_WORDS)) && (ker_need <= 32'(KER_WORDS));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign mode_q  = g_q.mode;
    assign nsvm_q  = g_q.nsvm;
    assign rows_q  = g_q.rows;
    assign kerns_q = g_q.kerns;
    assign k_q     = g_q.k;
    assign fits_q  = g_q.fits;

    // R2: captured geometry cannot change while a layout is running
    p_geom_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(g_q));

    // R3: a captured window length is never zero
    p_k_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (g_q.k != '0));

endmodule

// File: rtl/svm_map_walk.sv
module svm_map_walk
    import svm_map_pkg::*;
#(
    parameter int TN_LG2 = 2,
    parameter int NW     = 7,
    parameter int RW     = 5,
    parameter int KW     = 5,
    parameter int AW     = 8,
    parameter int EW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              mode,
    input  logic [NW-1:0]     nsvm,
    input  logic [RW-1:0]     rows,
    input  logic [RW-1:0]     kerns,
    input  logic [KW-1:0]     k,
    output logic              busy,
    output logic              ready,
    output logic              wr_valid,
    output logic              wr_buf,
    output logic [TN_LG2-1:0] wr_chan,
    output logic [AW-1:0]     wr_addr,
    output logic              src_kind,
    output logic [RW-1:0]     src_row,
    output logic [EW-1:0]     src_elem,
    output logic              wr_zero
);
    localparam int TN = 1 << TN_LG2;
    localparam int CW = TN_LG2;

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] c;
        logic [KW-1:0] p;
        logic [RW-1:0] row;
        logic [AW-1:0] base;
        logic [EW-1:0] n;
    } walk_t;

    walk_t s_d, s_q;

    logic [RW-1:0] cnt;
    logic          last_c, last_p, last_r;

    always_comb begin
        cnt    = (s_q.ph == PH_KER) ? kerns : rows;
        last_c = (s_q.c == CW'(TN - 1));
        last_p = (s_q.p == k - KW'(1));
        last_r = (s_q.row == cnt - RW'(1));

        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE, PH_DONE: begin
                if (accept) begin
                    s_d    = '0;
                    s_d.ph = PH_FM;
                end
            end
            PH_FM, PH_KER: begin
                s_d.c = s_q.c + CW'(1);
                s_d.n = s_q.n + EW'(1);
                if (last_c) begin
                    s_d.p = s_q.p + KW'(1);
                    if (last_p) begin
                        s_d.p = '0;
                        s_d.n = '0;
                        if (last_r) begin
                            s_d.row  = '0;
                            s_d.base = '0;
                            s_d.ph   = (s_q.ph == PH_FM) ? PH_KER : PH_DONE;
                        end else begin
                            s_d.row  = s_q.row + RW'(1);
                            s_d.base = s_q.base + AW'(k);
                        end
                    end
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = (s_q.ph == PH_FM) || (s_q.ph == PH_KER);
    assign ready    = (s_q.ph == PH_DONE);
    assign wr_valid = busy;
    assign wr_buf   = (s_q.ph == PH_KER);
    assign wr_chan  = s_q.c;
    assign wr_addr  = s_q.base + AW'(s_q.p);
    assign src_kind = mode ^ wr_buf;
    assign src_row  = s_q.row;
    assign src_elem = s_q.n;
    assign wr_zero  = (32'(s_q.n) >= 32'(nsvm));

    // R7: channel advances by one, wrapping, on every consecutive write
    p_chan_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wr_valid)) |-> (wr_chan == CW'($past(wr_chan) + 1'b1)));

    // R7: address stays inside the rows times window area of the phase
    p_addr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (32'(wr_addr) < 32'(cnt) * 32'(k)));

    // R6: no feature-map write follows a kernel write
    p_buf_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_buf) |=> !(wr_valid && !wr_buf));

    // R8: within a row, a data write is never preceded by a pad write
    p_pad_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_zero && $past(wr_valid) && (src_elem != '0)) |-> !$past(wr_zero));

endmodule

// File: rtl/svm_operand_mapper.sv
module svm_operand_mapper #(
    parameter int TN_LG2    = 2,
    parameter int MAX_N     = 64,
    parameter int MAX_M     = 16,
    parameter int MAX_B     = 16,
    parameter int FM_WORDS  = 512,
    parameter int KER_WORDS = 512,
    localparam int TN       = 1 << TN_LG2,
    localparam int MAX_K    = (MAX_N + TN - 1) / TN,
    localparam int MAX_R    = (MAX_M > MAX_B) ? MAX_M : MAX_B,
    localparam int NW       = $clog2(MAX_N + 1),
    localparam int BW       = $clog2(MAX_B + 1),
    localparam int MW       = $clog2(MAX_M + 1),
    localparam int RW       = $clog2(MAX_R + 1),
    localparam int KW       = $clog2(MAX_K + 1),
    localparam int AW       = $clog2(MAX_R * MAX_K),
    localparam int EW       = $clog2(MAX_K * TN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic [BW-1:0]     batch,
    input  logic [MW-1:0]     msvm,
    input  logic [NW-1:0]     nsvm,
    output logic              ready,
    output logic              wr_valid,
    output logic              wr_buf,
    output logic [TN_LG2-1:0] wr_chan,
    output logic [AW-1:0]     wr_addr,
    output logic              src_kind,
    output logic [RW-1:0]     src_row,
    output logic [EW-1:0]     src_elem,
    output logic              wr_zero,
    output logic [RW-1:0]     geo_fm_rows,
    output logic [KW-1:0]     geo_fm_cols,
    output logic [RW-1:0]     geo_out_ch,
    output logic [RW-1:0]     geo_out_size,
    output logic [KW-1:0]     geo_ker_len,
    output logic [KW-1:0]     geo_stride,
    output logic              geo_fits
);
    logic          busy, accept, dims_ok;
    logic          mode_q, fits_q;
    logic [NW-1:0] nsvm_q;
    logic [RW-1:0] rows_q, kerns_q;
    logic [KW-1:0] k_q;

    assign dims_ok = (batch != '0) && (msvm != '0) && (nsvm != '0);
    assign accept  = start && !busy && dims_ok;

    svm_map_geom #(
        .TN_LG2(TN_LG2), .NW(NW), .BW(BW), .MW(MW), .RW(RW), .KW(KW),
        .FM_WORDS(FM_WORDS), .KER_WORDS(KER_WORDS)
    ) u_geom (
        .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy),
        .mode(mode), .batch(batch), .msvm(msvm), .nsvm(nsvm),
        .mode_q(mode_q), .nsvm_q(nsvm_q), .rows_q(rows_q),
        .kerns_q(kerns_q), .k_q(k_q), .fits_q(fits_q)
    );

    svm_map_walk #(
        .TN_LG2(TN_LG2), .NW(NW), .RW(RW), .KW(KW), .AW(AW), .EW(EW)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .accept(accept), .mode(mode_q),
        .nsvm(nsvm_q), .rows(rows_q), .kerns(kerns_q), .k(k_q),
        .busy(busy), .ready(ready), .wr_valid(wr_valid), .wr_buf(wr_buf),
        .wr_chan(wr_chan), .wr_addr(wr_addr), .src_kind(src_kind),
        .src_row(src_row), .src_elem(src_elem), .wr_zero(wr_zero)
    );

    assign geo_fm_rows  = rows_q;
    assign geo_fm_cols  = k_q;
    assign geo_out_ch   = kerns_q;
    assign geo_out_size = rows_q;
    assign geo_ker_len  = k_q;
    assign geo_stride   = k_q;
    assign geo_fits     = fits_q;

    // R10: a finished layout issues no writes
    p_ready_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !wr_valid);

    // R2: a rejected start from idle leaves the write port quiet
    p_reject_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !dims_ok) |=> !wr_valid);

    // R6: the first write follows an accepted start by one cycle
    p_first_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (wr_valid && !wr_buf && (wr_addr == '0)));

endmodule

// File: tb/sim_svm_operand_mapper.sv
module sim_svm_operand_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int TN = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mode = 1'b0;
    logic [2:0] batch = '0;
    logic [2:0] msvm = '0;
    logic [3:0] nsvm = '0;
    logic       ready, wr_valid, wr_buf, src_kind, wr_zero, geo_fits;
    logic [1:0] wr_chan, geo_fm_cols, geo_ker_len, geo_stride;
    logic [3:0] wr_addr, src_elem;
    logic [2:0] src_row, geo_fm_rows, geo_out_ch, geo_out_size;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svm_operand_mapper #(
        .TN_LG2(2), .MAX_N(10), .MAX_M(4), .MAX_B(4),
        .FM_WORDS(8), .KER_WORDS(12)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .batch(batch), .msvm(msvm), .nsvm(nsvm),
        .ready(ready), .wr_valid(wr_valid), .wr_buf(wr_buf),
        .wr_chan(wr_chan), .wr_addr(wr_addr), .src_kind(src_kind),
        .src_row(src_row), .src_elem(src_elem), .wr_zero(wr_zero),
        .geo_fm_rows(geo_fm_rows), .geo_fm_cols(geo_fm_cols),
        .geo_out_ch(geo_out_ch), .geo_out_size(geo_out_size),
        .geo_ker_len(geo_ker_len), .geo_stride(geo_stride),
        .geo_fits(geo_fits)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_geom(input int m, input int b, input int ms, input int ns);
        int k = (ns + TN - 1) / TN;
        int rows = m ? ms : b;
        int kern = m ? b : ms;
        int fits = ((rows * k <= 8) && (kern * k <= 12)) ? 1 : 0;
        chk("R3 window", {geo_fm_cols, geo_ker_len, geo_stride}, {k[1:0], k[1:0], k[1:0]});
        if (m == 0) chk("R4 mode0 geometry", {geo_fm_rows, geo_out_size, geo_out_ch},
                        {b[2:0], b[2:0], ms[2:0]});
        else        chk("R5 mode1 geometry", {geo_fm_rows, geo_out_size, geo_out_ch},
                        {ms[2:0], ms[2:0], b[2:0]});
        chk("R11 fits", int'(geo_fits), fits);
    endtask

    task automatic run(input int m, input int b, input int ms, input int ns, input int intr);
        int k = (ns + TN - 1) / TN;
        int idx = 0;
        @(negedge clk);
        mode = m[0]; batch = b[2:0]; msvm = ms[2:0]; nsvm = ns[3:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_geom(m, b, ms, ns);
        for (int ph = 0; ph < 2; ph++) begin
            int cnt = (ph == 0) ? (m ? ms : b) : (m ? b : ms);
            for (int r = 0; r < cnt; r++) begin
                for (int p = 0; p < k; p++) begin
                    for (int c = 0; c < TN; c++) begin
                        int e = p * TN + c;
                        int ek = m ^ ph;
                        chk("R6 valid/buffer", {wr_valid, wr_buf}, {1'b1, ph[0]});
                        chk("R7 channel/address", {wr_chan, wr_addr}, {c[1:0], 4'(r * k + p)});
                        chk("R8 pad", int'(wr_zero), (e >= ns) ? 1 : 0);
                        chk("R9 source", {src_kind, src_row, src_elem}, {ek[0], r[2:0], e[3:0]});
                        chk("R10 not ready mid-run", int'(ready), 0);
                        if (idx == intr) begin
                            // R2: start with other settings during the run
                            mode = ~m[0]; batch = 3'd1; msvm = 3'd4; nsvm = 4'd10; start = 1'b1;
                        end else begin
                            start = 1'b0;
                        end
                        idx++;
                        @(negedge clk);
                    end
                end
            end
        end
        start = 1'b0;
        mode = m[0]; batch = b[2:0]; msvm = ms[2:0]; nsvm = ns[3:0];
        chk("R10 ready after last write", {ready, wr_valid}, {1'b1, 1'b0});
        chk_geom(m, b, ms, ns);
        @(negedge clk);
        @(negedge clk);
        chk("R10 ready holds", {ready, wr_valid}, {1'b1, 1'b0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset outputs", {ready, wr_valid}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {ready, wr_valid}, 2'b00);

        // R2: starts with a zero dimension are rejected
        mode = 1'b0; batch = 3'd0; msvm = 3'd2; nsvm = 4'd5; start = 1'b1;
        @(negedge clk);
        chk("R2 zero batch rejected", {ready, wr_valid}, 2'b00);
        mode = 1'b1; batch = 3'd2; msvm = 3'd2; nsvm = 4'd0;
        @(negedge clk);
        chk("R2 zero nsvm rejected", {ready, wr_valid}, 2'b00);
        batch = 3'd2; msvm = 3'd0; nsvm = 4'd3;
        @(negedge clk);
        start = 1'b0;
        chk("R2 zero msvm rejected", {ready, wr_valid, geo_fm_cols}, 4'b0000);

        for (int m = 0; m < 2; m++)
            for (int b = 1; b <= 3; b++)
                for (int ms = 1; ms <= 3; ms++)
                    for (int ns = 1; ns <= 9; ns++)
                        run(m, b, ms, ns, (b + ms + ns) % 4);

        // R2: a rejected start while finished keeps ready and geometry
        @(negedge clk);
        nsvm = 4'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 zero start after done", {ready, wr_valid}, 2'b10);
        chk_geom(1, 3, 3, 9);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule